// File: doc/BRIEF.md
# Address Translation Window Unit

This unit maps addresses issued by a memory-mapped master into addresses on a wider internal fabric. It holds six programmable windows, and each window has three registers. The start register gives the first master-side byte covered. The page-count register gives the window length in 4 KB pages. The fabric-word register describes where the window lands on the fabric side. A small write/read register port programs the windows. A lookup port accepts one master address per cycle and returns, one cycle later, whether a window claimed it, which window that was, and the translated 40-bit fabric address.

The fabric word can be read in two ways, chosen by its bit 0. Memory windows set bit 0 and carry a page number in bits 31:4. Other windows, such as configuration and downstream I/O, carry the fabric address bits 39:8 directly. If no enabled window covers an address, the lookup reports a decode error instead of a hit. When windows overlap, the lowest-numbered window is chosen.

Top module: `addr_xlat_top`

## Requirements
- R1: After reset all twelve-plus-six window registers read as zero, every window is disabled, and a lookup returns a decode error.
- R2: Registers sit at word offsets (byte offset, cfg_addr[1:0] = 0): page count of window i at 0x00+4i, start at 0x18+4i, fabric word at 0x30+4i. A read returns the stored value, and the page count is limited to its low 20 bits. Writes to any other offset, including misaligned ones, change nothing and read back as zero.
- R3: Window i hits address A when start <= A < start + pages*4096, evaluated without wrap-around. The last byte of a window hits and the byte just past it misses.
- R4: A window whose page count is zero never hits.
- R5: If bit 0 of the fabric word is 1, the fabric base is word[31:4] multiplied by 4096.
- R6: If bit 0 of the fabric word is 0, the fabric base is the word multiplied by 256.
- R7: On a hit, the translated address is the fabric base plus (A − start), 40 bits wide.
- R8: When several windows hit, the lowest-numbered one is reported in rsp_idx and used for translation.
- R9: On a miss, rsp_decerr is 1 and rsp_hit, rsp_idx and rsp_addr are 0.
- R10: The response appears exactly one clock after lk_valid is sampled. In a cycle with no response, all response outputs are 0.
- R11: A lookup sampled on the same edge as a register write uses the old settings. A lookup on the next edge uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Master-side address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_decerr | output | 1 | No window claimed the address |
| rsp_idx | output | 3 | Index of the claiming window |
| rsp_addr | output | 40 | Translated fabric address |

## Verification
On every cycle the assertions check the structural properties of the lookup. The response follows the request by exactly one clock. Hit and decode error are mutually exclusive. A disabled window never matches, and the chosen window is the lowest matching one and one of those that matched. The arithmetic cannot be checked that way and is left to the bench's scenarios: the window limits, the two fabric-word decodings, the translated offsets, the register offset map and its ignored writes, and the ordering of a write against a lookup on the same edge. The bench recomputes each of these from its own model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int XL_ADDR_W  = 32;
  parameter int XL_PAGE_SH = 12;
  parameter int XL_SIZE_W  = XL_ADDR_W - XL_PAGE_SH;
  parameter int XL_FAB_W   = 40;
  parameter int XL_RAW_SH  = XL_FAB_W - XL_ADDR_W;
  parameter int XL_PGN_LSB = 4;

  typedef logic [XL_ADDR_W-1:0] axi_addr_t;
  typedef logic [XL_SIZE_W-1:0] pages_t;
  typedef logic [XL_FAB_W-1:0]  fab_addr_t;
  typedef logic [XL_ADDR_W:0]   limit_t;

  typedef struct packed {
    pages_t    pages;
    axi_addr_t start;
    axi_addr_t word;
  } win_cfg_t;

  // Fabric base from the programmed word: bit 0 selects page-number form.
  function automatic fab_addr_t decode_fab_base(axi_addr_t w);
    fab_addr_t b;
    if (w[0]) b = fab_addr_t'(w[XL_ADDR_W-1:XL_PGN_LSB]) << XL_PAGE_SH;
    else      b = fab_addr_t'(w) << XL_RAW_SH;
    return b;
  endfunction

  // Exclusive upper bound of a window, one bit wider than the address.
  function automatic limit_t win_limit(axi_addr_t st, pages_t pg);
    limit_t span;
    span = limit_t'(pg) << XL_PAGE_SH;
    return limit_t'(st) + span;
  endfunction

  function automatic logic win_covers(axi_addr_t a, axi_addr_t st, pages_t pg);
    return (pg != '0) && (a >= st) && (limit_t'(a) < win_limit(st, pg));
  endfunction

  function automatic fab_addr_t translate(fab_addr_t base, axi_addr_t a, axi_addr_t st);
    axi_addr_t ofs;
    ofs = a - st;
    return base + fab_addr_t'(ofs);
  endfunction
endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int CFG_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [XL_ADDR_W-1:0]     cfg_wdata,
  output logic [XL_ADDR_W-1:0]     cfg_rdata,
  output win_cfg_t [NUM_WIN-1:0]   cfg_q,
  output logic [NUM_WIN-1:0]       idle_o
);
  localparam int WORD_IDX_W = CFG_AW - 2;
  localparam int SIZE_OFS   = 0;
  localparam int START_OFS  = NUM_WIN;
  localparam int WORD_OFS   = 2 * NUM_WIN;

  logic                  aligned;
  logic [WORD_IDX_W-1:0] word_idx;

  assign aligned  = (cfg_addr[1:0] == 2'b00);
  assign word_idx = cfg_addr[CFG_AW-1:2];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    pages_t    pages_q;
    axi_addr_t start_q;
    axi_addr_t word_q;
    logic      sel_size, sel_start, sel_word;

    assign sel_size  = cfg_wr && aligned && (word_idx == WORD_IDX_W'(SIZE_OFS + i));
    assign sel_start = cfg_wr && aligned && (word_idx == WORD_IDX_W'(START_OFS + i));
    assign sel_word  = cfg_wr && aligned && (word_idx == WORD_IDX_W'(WORD_OFS + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pages_q <= '0;
        start_q <= '0;
        word_q  <= '0;
      end else begin
        if (sel_size)  pages_q <= cfg_wdata[XL_SIZE_W-1:0];
        if (sel_start) start_q <= cfg_wdata;
        if (sel_word)  word_q  <= cfg_wdata;
      end
    end

    assign cfg_q[i] = '{pages: pages_q, start: start_q, word: word_q};
    assign idle_o[i] = (pages_q == '0);
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (aligned && word_idx == WORD_IDX_W'(SIZE_OFS + i))
        cfg_rdata = XL_ADDR_W'(cfg_q[i].pages);
      if (aligned && word_idx == WORD_IDX_W'(START_OFS + i))
        cfg_rdata = cfg_q[i].start;
      if (aligned && word_idx == WORD_IDX_W'(WORD_OFS + i))
        cfg_rdata = cfg_q[i].word;
    end
  end
endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
  import xlat_pkg::*;
(
  input  win_cfg_t  cfg_i,
  input  axi_addr_t addr_i,
  output logic      match_o,
  output fab_addr_t xaddr_o
);
  fab_addr_t base;

  assign base    = decode_fab_base(cfg_i.word);
  assign match_o = win_covers(addr_i, cfg_i.start, cfg_i.pages);
  assign xaddr_o = translate(base, addr_i, cfg_i.start);
endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]      match_i,
  input  fab_addr_t [NUM_WIN-1:0] xaddr_i,
  output logic [NUM_WIN-1:0]      grant_o,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o,
  output fab_addr_t               addr_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NUM_WIN; i++)
      addr_o = addr_o | (xaddr_i[i] & {XL_FAB_W{grant_o[i]}});
  end
endmodule

// File: rtl/addr_xlat_top.sv
module addr_xlat_top
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int CFG_AW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [XL_ADDR_W-1:0]       cfg_wdata,
  output logic [XL_ADDR_W-1:0]       cfg_rdata,
  input  logic                       lk_valid,
  input  logic [XL_ADDR_W-1:0]       lk_addr,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_decerr,
  output logic [$clog2(NUM_WIN)-1:0] rsp_idx,
  output logic [XL_FAB_W-1:0]        rsp_addr
);
  localparam int IDX_W = $clog2(NUM_WIN);

  win_cfg_t  [NUM_WIN-1:0] win_cfg;
  fab_addr_t [NUM_WIN-1:0] win_xaddr;
  logic      [NUM_WIN-1:0] win_match;
  logic      [NUM_WIN-1:0] win_grant;
  logic      [NUM_WIN-1:0] win_idle;
  logic                    pick_any;
  logic      [IDX_W-1:0]   pick_idx;
  fab_addr_t               pick_addr;
  logic                    lk_fire_hit;
  logic                    lk_fire_miss;

  xlat_regfile #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_q     (win_cfg),
    .idle_o    (win_idle)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    xlat_win_match u_match (
      .cfg_i   (win_cfg[g]),
      .addr_i  (lk_addr),
      .match_o (win_match[g]),
      .xaddr_o (win_xaddr[g])
    );
  end

  xlat_prio_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .match_i (win_match),
    .xaddr_i (win_xaddr),
    .grant_o (win_grant),
    .any_o   (pick_any),
    .idx_o   (pick_idx),
    .addr_o  (pick_addr)
  );

  assign lk_fire_hit  = lk_valid && pick_any;
  assign lk_fire_miss = lk_valid && !pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_decerr <= 1'b0;
      rsp_idx    <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_fire_hit;
      rsp_decerr <= lk_fire_miss;
      rsp_idx    <= lk_fire_hit ? pick_idx  : '0;
      rsp_addr   <= lk_fire_hit ? pick_addr : '0;
    end
  end
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3,
  parameter int FAB_W   = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_decerr,
  input logic [IDX_W-1:0]   rsp_idx,
  input logic [FAB_W-1:0]   rsp_addr,
  input logic [NUM_WIN-1:0] win_match,
  input logic [NUM_WIN-1:0] win_grant,
  input logic [NUM_WIN-1:0] win_idle
);
  p_req_to_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_no_req_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_decerr && rsp_addr == '0 && rsp_idx == '0));
  p_hit_xor_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_decerr));
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_decerr |-> (rsp_addr == '0 && rsp_idx == '0));
  p_miss_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && win_match == '0) |=> rsp_decerr);
  p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && win_match != '0) |=> rsp_hit);
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_idle & win_match) == '0);
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_grant));
  p_grant_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_grant & ~win_match) == '0);
  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_match != '0 |-> (win_grant != '0 && ((win_grant - 1'b1) & win_match) == '0));
  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_idx) < NUM_WIN));
endmodule

bind addr_xlat_top xlat_checker #(
  .NUM_WIN (NUM_WIN),
  .IDX_W   ($clog2(NUM_WIN)),
  .FAB_W   (xlat_pkg::XL_FAB_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_decerr (rsp_decerr),
  .rsp_idx    (rsp_idx),
  .rsp_addr   (rsp_addr),
  .win_match  (win_match),
  .win_grant  (win_grant),
  .win_idle   (win_idle)
);

// File: tb/addr_xlat_top_tb_top.sv
`timescale 1ns/1ps
module addr_xlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_decerr;
  logic [2:0]  rsp_idx;
  logic [39:0] rsp_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sz [6];
  logic [31:0] m_st [6];
  logic [31:0] m_wd [6];

  always #2 clk = ~clk;

  addr_xlat_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_decerr(rsp_decerr), .rsp_idx(rsp_idx), .rsp_addr(rsp_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_base(logic [31:0] w);
    if (w[0]) return 40'(longint'(w >> 4) * 64'd4096);
    return 40'(longint'(w) * 64'd256);
  endfunction

  task automatic model_lookup(input logic [31:0] a, output bit hit, output int idx, output logic [39:0] xa);
    hit = 0; idx = 0; xa = '0;
    for (int i = 5; i >= 0; i--) begin
      if (m_sz[i] != 0 && longint'(a) >= longint'(m_st[i]) &&
          longint'(a) < longint'(m_st[i]) + longint'(m_sz[i]) * 64'd4096) begin
        hit = 1; idx = i;
        xa = 40'(longint'(exp_base(m_wd[i])) + longint'(a) - longint'(m_st[i]));
      end
    end
  endtask

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    int k;
    if (a[1:0] != 2'b00) return;
    k = int'(a[7:2]);
    if (k < 6)       m_sz[k]    = d & 32'h000F_FFFF;
    else if (k < 12) m_st[k-6]  = d;
    else if (k < 18) m_wd[k-12] = d;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int k;
    if (a[1:0] != 2'b00) return '0;
    k = int'(a[7:2]);
    if (k < 6)  return m_sz[k];
    if (k < 12) return m_st[k-6];
    if (k < 18) return m_wd[k-12];
    return '0;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = model_read(a);
    cfg_addr = a;
    #0.5;
    chk(cfg_rdata === e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic lookup_check(input logic [31:0] a, input string tag);
    bit eh; int ei; logic [39:0] ea;
    model_lookup(a, eh, ei, ea);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === eh && rsp_decerr === !eh &&
        rsp_idx === 3'(ei) && rsp_addr === ea, tag,
        64'({rsp_valid, rsp_hit, rsp_decerr, rsp_idx, rsp_addr}),
        64'({1'b1, eh, !eh, 3'(ei), ea}));
  endtask

  task automatic lookup_lit(input logic [31:0] a, input bit eh, input logic [2:0] ei,
                            input logic [39:0] ea, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_hit === eh && rsp_decerr === !eh && rsp_idx === ei && rsp_addr === ea, tag,
        64'({rsp_hit, rsp_decerr, rsp_idx, rsp_addr}), 64'({eh, !eh, ei, ea}));
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin m_sz[i] = 0; m_st[i] = 0; m_wd[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    for (int a = 0; a < 72; a += 4) rd_check(8'(a), "R1 register reset value");
    lookup_lit(32'h8000_4000, 1'b0, 3'd0, 40'd0, "R1 lookup after reset misses");

    // Program a typical map
    cfg_write(8'h18, 32'h8000_4000); cfg_write(8'h00, 32'h100); cfg_write(8'h30, 32'hFDFF_0000);
    cfg_write(8'h1C, 32'h8010_4000); cfg_write(8'h04, 32'h100); cfg_write(8'h34, 32'hFE10_0000);
    cfg_write(8'h20, 32'h8040_0000); cfg_write(8'h08, 32'h20);  cfg_write(8'h38, 32'hFDFC_0000);
    cfg_write(8'h24, 32'hA000_0000); cfg_write(8'h0C, 32'h20000); cfg_write(8'h3C, 32'h00A0_0001);
    cfg_write(8'h28, 32'h9000_0000); cfg_write(8'h10, 32'h10000); cfg_write(8'h40, 32'h0090_0001);

    // R2: readback
    for (int a = 0; a < 72; a += 4) rd_check(8'(a), "R2 readback");
    cfg_write(8'h14, 32'hFFFF_FFFF);
    rd_check(8'h14, "R2 size limited to 20 bits");
    cfg_write(8'h14, 32'h0);

    // R6 / R7: raw-form base, literal values
    lookup_lit(32'h8000_4010, 1'b1, 3'd0, 40'hFD_FF00_0010, "R6 config window translation");
    lookup_lit(32'h8010_5004, 1'b1, 3'd1, 40'hFE_1000_1004, "R7 ext window translation");
    // R3: window edges
    lookup_lit(32'h8041_FFFF, 1'b1, 3'd2, 40'hFD_FC01_FFFF, "R3 last byte hits");
    lookup_lit(32'h8042_0000, 1'b0, 3'd0, 40'd0, "R3 end byte misses (R9)");
    lookup_lit(32'h8000_3FFF, 1'b0, 3'd0, 40'd0, "R3 byte below start misses");
    // R5: page-form base
    lookup_lit(32'hA123_4568, 1'b1, 3'd3, 40'h00_A123_4568, "R5 prefetch window translation");
    lookup_lit(32'h9FFF_FFFC, 1'b1, 3'd4, 40'h00_9FFF_FFFC, "R5 memory window translation");

    // R8: overlap, lowest wins
    cfg_write(8'h2C, 32'h9000_0000); cfg_write(8'h14, 32'h10); cfg_write(8'h44, 32'h1234_5671);
    lookup_lit(32'h9000_0100, 1'b1, 3'd4, 40'h00_9000_0100, "R8 lower index wins");
    // R4: size zero disables
    cfg_write(8'h10, 32'h0);
    lookup_lit(32'h9000_0100, 1'b1, 3'd5, 40'h12_3456_7100, "R4 disabled window skipped");
    lookup_lit(32'h9001_0000, 1'b0, 3'd0, 40'd0, "R4 size zero never matches");
    // R3: window at top of address space, no wrap
    cfg_write(8'h10, 32'h1); cfg_write(8'h28, 32'hFFFF_F000); cfg_write(8'h40, 32'h0000_0011);
    lookup_lit(32'hFFFF_FFFF, 1'b1, 3'd4, 40'h00_0000_1FFF, "R3 top-of-space window");
    lookup_check(32'h0000_0000, "R3 no wrap to zero");

    // R2: ignored writes
    cfg_write(8'h48, 32'hDEAD_BEEF); cfg_write(8'hFC, 32'h1);
    cfg_write(8'h01, 32'h0);  cfg_write(8'h1A, 32'h0);
    for (int a = 0; a < 76; a += 4) rd_check(8'(a), "R2 ignored writes leave registers");
    rd_check(8'h49, "R2 misaligned reads zero");
    lookup_check(32'h8000_4000, "R2 lookup unchanged after ignored writes");

    // R10: idle cycle is quiet
    @(negedge clk);
    chk(rsp_valid === 0 && rsp_hit === 0 && rsp_decerr === 0 && rsp_addr === 0, "R10 idle outputs zero",
        64'({rsp_valid, rsp_hit, rsp_decerr, rsp_addr}), 64'd0);

    // R11: write and lookup on the same edge
    cfg_write(8'h2C, 32'h6000_0000);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h2C; cfg_wdata = 32'h7000_0000;
    lk_valid = 1'b1; lk_addr = 32'h7000_0040;
    @(negedge clk);
    cfg_wr = 1'b0; lk_valid = 1'b0;
    chk(rsp_decerr === 1'b1 && rsp_hit === 1'b0, "R11 same-edge lookup sees old start",
        64'({rsp_hit, rsp_decerr}), 64'b01);
    model_write(8'h2C, 32'h7000_0000);
    lookup_lit(32'h7000_0040, 1'b1, 3'd5, 40'h12_3456_7040, "R11 next lookup sees new start");

    // Random phase: R3 R5 R6 R7 R8
    begin
      int unsigned s;
      s = $urandom(32'h5EED_1234);
      for (int it = 0; it < 600; it++) begin
        int w; logic [31:0] a;
        if ($urandom_range(0, 7) == 0) begin
          w = $urandom_range(0, 5);
          case ($urandom_range(0, 2))
            0: cfg_write(8'(4*w), 32'($urandom_range(0, 40)));
            1: cfg_write(8'(24 + 4*w), {2'($urandom_range(0, 3)), 30'h0} + {14'h0, 6'($urandom_range(0, 63)), 12'h0});
            default: cfg_write(8'(48 + 4*w), $urandom());
          endcase
        end
        w = $urandom_range(0, 5);
        if ($urandom_range(0, 3) == 0) a = $urandom();
        else a = m_st[w] + 32'($urandom_range(0, 45 * 4096)) - 32'd64;
        lookup_check(a, "R7 random translation (R3 R5 R6 R8)");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule